// File: doc/BRIEF.md
# PCM Audio Sample FIFO Pair with Threshold Interrupts

This block sits between the register bus and the serial shifter of a PCM audio port. It holds two sample queues: a transmit queue that software or DMA fills from the bus and the serializer drains, and a receive queue that the serializer fills and the bus drains. Each queue reports how many samples it holds and raises empty, near-empty, full and near-full flags. A programmable threshold per direction decides when a DMA request is raised, so that the DMA engine tops up transmit before it runs dry and empties receive before it overflows.

Each queue is run by a four-state controller. FS_OFF is held while the queue's enable is low. The queue stays there until the enable rises, and then behaves as FS_EMPTY. FS_EMPTY moves to FS_PART on an accepted write. FS_PART moves to FS_FULL when a lone write fills the last slot, and back to FS_EMPTY when a lone read takes the last sample. FS_FULL returns to FS_PART on any read. Dropping the enable forces FS_OFF from any state and flushes the queue. Twelve sticky status bits record level conditions and error events: overflow (a write to a full queue) and starvation (a read from an empty one). A mask and a master enable turn them into one interrupt line.

Top module: `pcm_afifo_pair`

## Requirements
- R1: Each accepted write adds one to a queue's count and each accepted read subtracts one; samples leave in the order they arrived; the count stays within 0 to DEPTH (32).
- R2: A read port presents a 17-bit word: bit 16 is 1 and bits 15:0 hold the oldest sample when the queue holds data; the whole word is 0 when the queue is empty.
- R3: The empty flag is 1 exactly when the count is 0, and the full flag is 1 exactly when the count equals DEPTH.
- R4: The transmit near-empty flag is 1 when the count is at or below `tx_thresh`; the transmit near-full flag is 1 when the count is at or above DEPTH minus MARGIN (30).
- R5: The receive near-full flag is 1 when the count is at or above `rx_thresh`; the receive near-empty flag is 1 when the count is at or below MARGIN (2).
- R6: `tx_dma_req` equals transmit DMA enable AND transmit queue enable AND transmit near-empty; `rx_dma_req` equals receive DMA enable AND receive queue enable AND receive near-full.
- R7: A write to a full queue is dropped: the count and stored samples are unchanged. The overflow status bit (6 for transmit, 0 for receive) is set at the edge of the attempt.
- R8: A read from an empty queue returns an all-zero word and leaves the count at 0. The starvation status bit (7 for transmit, 1 for receive) is set at the edge of the attempt.
- R9: While a queue is enabled, each of its level flags sets a status bit one edge after the flag rises. The receive bits are near-full 2, full 3, near-empty 4 and empty 5. The transmit bits are near-full 8, full 9, near-empty 10 and empty 11. Bit 12 reads 0.
- R10: Status bits stay set until a 1 is written to the matching `irq_clear` bit; if the bit's condition is present in the clearing cycle, the bit stays set.
- R11: Status bit 13 is the OR of status bits 11:0 ANDed with `irq_en_mask`; `irq` is bit 13 ANDed with `irq_master_en`.
- R12: A disabled queue has count 0 one edge after its enable falls, accepts no writes or reads, and sets none of its status bits; on re-enable it holds no earlier sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_fifo_en | input | 1 | Transmit queue enable; low flushes |
| rx_fifo_en | input | 1 | Receive queue enable; low flushes |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_thresh | input | 6 | Transmit near-empty threshold |
| rx_thresh | input | 6 | Receive near-full threshold |
| bus_tx_wr | input | 1 | Bus write strobe into transmit queue |
| bus_tx_data | input | 16 | Sample written into transmit queue |
| bus_rx_rd | input | 1 | Bus read strobe from receive queue |
| bus_rx_word | output | 17 | Receive head word, valid at bit 16 |
| ser_tx_rd | input | 1 | Serializer read strobe from transmit queue |
| ser_tx_word | output | 17 | Transmit head word, valid at bit 16 |
| ser_rx_wr | input | 1 | Serializer write strobe into receive queue |
| ser_rx_data | input | 16 | Sample written into receive queue |
| tx_count | output | 6 | Transmit occupancy |
| tx_empty | output | 1 | Transmit empty |
| tx_aempty | output | 1 | Transmit near-empty |
| tx_full | output | 1 | Transmit full |
| tx_afull | output | 1 | Transmit near-full |
| rx_count | output | 6 | Receive occupancy |
| rx_empty | output | 1 | Receive empty |
| rx_aempty | output | 1 | Receive near-empty |
| rx_full | output | 1 | Receive full |
| rx_afull | output | 1 | Receive near-full |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq_en_mask | input | 12 | Per-condition interrupt enables, aligned with status bits 11:0 |
| irq_master_en | input | 1 | Global interrupt enable |
| irq_clear | input | 12 | Write-one-to-clear pulses for status bits 11:0 |
| irq_status | output | 14 | Sticky status, bit 13 pending |
| irq | output | 1 | Combined interrupt |

## Verification
Counts, flags, head words and DMA requests change at the edge that accepts the write or read. Overflow and starvation bits are set at that same edge. Level-driven status bits lag their flag by one more edge. Pending and `irq` follow the status, mask and master enable with no register between them. The bench changes inputs 2 ns after a rising edge and samples before the next one, so each check sees the result of exactly the edges counted above. The level-status check samples once before and once after the extra edge to confirm the lag.

// File: rtl/pcm_afifo_pkg.sv
package pcm_afifo_pkg;

    typedef enum logic [1:0] {
        FS_OFF   = 2'd0,
        FS_EMPTY = 2'd1,
        FS_PART  = 2'd2,
        FS_FULL  = 2'd3
    } fifo_state_e;

    // One direction's condition group, lsb first: ovf, starve, afull, full, aempty, empty
    typedef struct packed {
        logic empty;
        logic aempty;
        logic full;
        logic afull;
        logic starve;
        logic ovf;
    } chan_evt_t;

    localparam int EVT_PER_DIR = 6;
    localparam int EVT_W       = 2 * EVT_PER_DIR;
    localparam int STAT_W      = EVT_W + 2;
    localparam int PEND_BIT    = 13;

endpackage

// File: rtl/afifo_chan.sv
module afifo_chan
    import pcm_afifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    parameter int THR_W  = 6,
    parameter int MARGIN = 2,
    parameter bit IS_TX  = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic                              dma_en,
    input  logic [THR_W-1:0]                  thr,
    input  logic                              wr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              rd,
    output logic [DATA_W:0]                   rword,
    output logic [$clog2(DEPTH+1)-1:0]        count,
    output logic                              empty,
    output logic                              aempty,
    output logic                              full,
    output logic                              afull,
    output logic                              dma_req,
    output chan_evt_t                         evt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    fifo_state_e       state_q, state_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              do_wr, do_rd;
    logic [CMP_W-1:0]  cnt_c, thr_c;

    assign do_wr = en && wr && (state_q != FS_FULL);
    assign do_rd = en && rd && ((state_q == FS_PART) || (state_q == FS_FULL));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = FS_OFF;
        end else begin
            unique case (state_q)
                FS_OFF:   state_d = do_wr ? FS_PART : FS_EMPTY;
                FS_EMPTY: if (do_wr) state_d = FS_PART;
                FS_PART: begin
                    if (do_wr && !do_rd && cnt_q == LAST)
                        state_d = FS_FULL;
                    else if (do_rd && !do_wr && cnt_q == ONE)
                        state_d = FS_EMPTY;
                end
                FS_FULL:  if (do_rd) state_d = FS_PART;
                default:  state_d = FS_OFF;
            endcase
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (!en)
            cnt_d = '0;
        else if (do_wr && !do_rd)
            cnt_d = cnt_q + ONE;
        else if (do_rd && !do_wr)
            cnt_d = cnt_q - ONE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_OFF;
            cnt_q   <= '0;
            wptr    <= '0;
            rptr    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (!en) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (do_wr) wptr <= wptr + PTR_W'(1);
                if (do_rd) rptr <= rptr + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    // outputs
    assign cnt_c = CMP_W'(cnt_q);
    assign thr_c = CMP_W'(thr);

    always_comb begin
        empty = (state_q == FS_OFF) || (state_q == FS_EMPTY);
        full  = (state_q == FS_FULL);
        count = cnt_q;
        rword = empty ? '0 : {1'b1, mem[rptr]};
    end

    generate
        if (IS_TX) begin : g_tx_flags
            assign aempty  = (cnt_c <= thr_c);
            assign afull   = (cnt_c >= CMP_W'(DEPTH - MARGIN));
            assign dma_req = en && dma_en && aempty;
        end else begin : g_rx_flags
            assign afull   = (cnt_c >= thr_c);
            assign aempty  = (cnt_c <= CMP_W'(MARGIN));
            assign dma_req = en && dma_en && afull;
        end
    endgenerate

    always_comb begin
        evt.ovf    = en && wr && full;
        evt.starve = en && rd && empty;
        evt.afull  = en && afull;
        evt.full   = en && full;
        evt.aempty = en && aempty;
        evt.empty  = en && empty;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_c <= CMP_W'(DEPTH)); // R1
    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (cnt_q == '0)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr && full && !rd) |=> $stable(cnt_q)); // R7
    AST_EMPTY_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd && empty && !wr) |=> (cnt_q == '0)); // R8
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/afifo_stat.sv
module afifo_stat
    import pcm_afifo_pkg::*;
#(
    parameter int NBITS = EVT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set,
    input  logic [NBITS-1:0] clr,
    input  logic [NBITS-1:0] en_mask,
    input  logic             master_en,
    output logic [NBITS+1:0] status,
    output logic             irq
);
    logic [NBITS-1:0] stat_q;
    logic             pending;

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | set;
    end

    always_comb begin
        pending = |(stat_q & en_mask);
        status  = {pending, 1'b0, stat_q};
        irq     = pending && master_en;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(stat_q) & ~$past(clr)) & ~stat_q) == '0)); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((stat_q & $past(set)) == $past(set))); // R10

endmodule

// File: rtl/pcm_afifo_pair.sv
module pcm_afifo_pair
    import pcm_afifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    parameter int THR_W  = 6,
    parameter int MARGIN = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tx_fifo_en,
    input  logic                        rx_fifo_en,
    input  logic                        tx_dma_en,
    input  logic                        rx_dma_en,
    input  logic [THR_W-1:0]            tx_thresh,
    input  logic [THR_W-1:0]            rx_thresh,
    input  logic                        bus_tx_wr,
    input  logic [DATA_W-1:0]           bus_tx_data,
    input  logic                        bus_rx_rd,
    output logic [DATA_W:0]             bus_rx_word,
    input  logic                        ser_tx_rd,
    output logic [DATA_W:0]             ser_tx_word,
    input  logic                        ser_rx_wr,
    input  logic [DATA_W-1:0]           ser_rx_data,
    output logic [$clog2(DEPTH+1)-1:0]  tx_count,
    output logic                        tx_empty,
    output logic                        tx_aempty,
    output logic                        tx_full,
    output logic                        tx_afull,
    output logic [$clog2(DEPTH+1)-1:0]  rx_count,
    output logic                        rx_empty,
    output logic                        rx_aempty,
    output logic                        rx_full,
    output logic                        rx_afull,
    output logic                        tx_dma_req,
    output logic                        rx_dma_req,
    input  logic [EVT_W-1:0]            irq_en_mask,
    input  logic                        irq_master_en,
    input  logic [EVT_W-1:0]            irq_clear,
    output logic [STAT_W-1:0]           irq_status,
    output logic                        irq
);
    chan_evt_t tx_evt, rx_evt;

    afifo_chan #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W), .MARGIN(MARGIN), .IS_TX(1'b1)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_fifo_en), .dma_en(tx_dma_en), .thr(tx_thresh),
        .wr(bus_tx_wr), .wdata(bus_tx_data), .rd(ser_tx_rd), .rword(ser_tx_word),
        .count(tx_count), .empty(tx_empty), .aempty(tx_aempty), .full(tx_full),
        .afull(tx_afull), .dma_req(tx_dma_req), .evt(tx_evt)
    );

    afifo_chan #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W), .MARGIN(MARGIN), .IS_TX(1'b0)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_fifo_en), .dma_en(rx_dma_en), .thr(rx_thresh),
        .wr(ser_rx_wr), .wdata(ser_rx_data), .rd(bus_rx_rd), .rword(bus_rx_word),
        .count(rx_count), .empty(rx_empty), .aempty(rx_aempty), .full(rx_full),
        .afull(rx_afull), .dma_req(rx_dma_req), .evt(rx_evt)
    );

    afifo_stat #(.NBITS(EVT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set({tx_evt, rx_evt}), .clr(irq_clear),
        .en_mask(irq_en_mask), .master_en(irq_master_en),
        .status(irq_status), .irq(irq)
    );

    AST_TX_DMA_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (tx_count <= tx_thresh)); // R6
    AST_RX_DMA_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (rx_count >= rx_thresh)); // R6

endmodule

// File: tb/tb_pcm_afifo_pair.sv
module tb_pcm_afifo_pair;
    localparam int B_RX_STARVE = 1, B_RX_AFULL = 2, B_RX_AEMPTY = 4;
    localparam int B_TX_OVF = 6, B_TX_STARVE = 7, B_TX_EMPTY = 11, B_PEND = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_fifo_en = 0, rx_fifo_en = 0, tx_dma_en = 0, rx_dma_en = 0;
    logic [5:0] tx_thresh = 6'd4, rx_thresh = 6'd3;
    logic bus_tx_wr = 0, bus_rx_rd = 0, ser_tx_rd = 0, ser_rx_wr = 0;
    logic [15:0] bus_tx_data = '0, ser_rx_data = '0;
    logic [16:0] bus_rx_word, ser_tx_word;
    logic [5:0] tx_count, rx_count;
    logic tx_empty, tx_aempty, tx_full, tx_afull;
    logic rx_empty, rx_aempty, rx_full, rx_afull;
    logic tx_dma_req, rx_dma_req;
    logic [11:0] irq_en_mask = '0, irq_clear = '0;
    logic irq_master_en = 0;
    logic [13:0] irq_status;
    logic irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pcm_afifo_pair dut (
        .clk(clk), .rst_n(rst_n), .tx_fifo_en(tx_fifo_en), .rx_fifo_en(rx_fifo_en),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en), .tx_thresh(tx_thresh),
        .rx_thresh(rx_thresh), .bus_tx_wr(bus_tx_wr), .bus_tx_data(bus_tx_data),
        .bus_rx_rd(bus_rx_rd), .bus_rx_word(bus_rx_word), .ser_tx_rd(ser_tx_rd),
        .ser_tx_word(ser_tx_word), .ser_rx_wr(ser_rx_wr), .ser_rx_data(ser_rx_data),
        .tx_count(tx_count), .tx_empty(tx_empty), .tx_aempty(tx_aempty),
        .tx_full(tx_full), .tx_afull(tx_afull), .rx_count(rx_count),
        .rx_empty(rx_empty), .rx_aempty(rx_aempty), .rx_full(rx_full),
        .rx_afull(rx_afull), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .irq_en_mask(irq_en_mask), .irq_master_en(irq_master_en),
        .irq_clear(irq_clear), .irq_status(irq_status), .irq(irq)
    );

    typedef struct packed {
        logic        twr;
        logic        trd;
        logic        rwr;
        logic        rrd;
        logic [15:0] d;
        logic [5:0]  etc;
        logic [5:0]  erc;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h1111, 6'd1, 6'd0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h2222, 6'd2, 6'd0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'hA001, 6'd2, 6'd1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'h3333, 6'd2, 6'd1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'hA002, 6'd2, 6'd1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 6'd1, 6'd1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 6'd1, 6'd0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 6'd0, 6'd0}
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tx_push(input logic [15:0] v);
        bus_tx_wr = 1'b1; bus_tx_data = v; tick(); bus_tx_wr = 1'b0;
    endtask

    task automatic rx_push(input logic [15:0] v);
        ser_rx_wr = 1'b1; ser_rx_data = v; tick(); ser_rx_wr = 1'b0;
    endtask

    task automatic tx_pop();
        ser_tx_rd = 1'b1; tick(); ser_tx_rd = 1'b0;
    endtask

    task automatic clear_all();
        irq_clear = '1; tick(); irq_clear = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // reset state, queues still disabled
        chk("R3 reset tx_empty", tx_empty, 1);
        chk("R1 reset tx_count", tx_count, 0);
        chk("R12 reset status with queues off", irq_status, 0);
        chk("R11 reset irq", irq, 0);
        chk("R2 reset rx word", bus_rx_word, 0);

        tx_fifo_en = 1'b1; rx_fifo_en = 1'b1;
        tick();

        // vector table: counts after each cycle
        for (int i = 0; i < 8; i++) begin
            bus_tx_wr = VECS[i].twr; ser_tx_rd = VECS[i].trd;
            ser_rx_wr = VECS[i].rwr; bus_rx_rd = VECS[i].rrd;
            bus_tx_data = VECS[i].d; ser_rx_data = VECS[i].d;
            tick();
            chk("R1 table tx_count", tx_count, VECS[i].etc);
            chk("R1 table rx_count", rx_count, VECS[i].erc);
        end
        bus_tx_wr = 0; ser_tx_rd = 0; ser_rx_wr = 0; bus_rx_rd = 0;

        // ordering and head word
        for (int i = 0; i < 5; i++) tx_push(16'h0100 + 16'(i));
        chk("R1 count after five", tx_count, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R2 head word order", ser_tx_word, {1'b1, 16'h0100 + 16'(i)});
            tx_pop();
        end
        chk("R2 empty word", ser_tx_word, 0);
        chk("R3 empty after drain", tx_empty, 1);

        // transmit threshold and DMA
        tx_dma_en = 1'b1;
        for (int i = 0; i < 4; i++) tx_push(16'h0040 + 16'(i));
        chk("R4 tx aempty at thr", tx_aempty, 1);
        chk("R6 tx dma at thr", tx_dma_req, 1);
        tx_push(16'h0044);
        chk("R4 tx aempty above thr", tx_aempty, 0);
        chk("R6 tx dma above thr", tx_dma_req, 0);
        tx_pop();
        tx_dma_en = 1'b0;
        #1;
        chk("R6 tx dma gated", tx_dma_req, 0);
        for (int i = 0; i < 4; i++) tx_pop();

        // fill and overflow
        clear_all();
        for (int i = 0; i < 32; i++) tx_push(16'h0200 + 16'(i));
        chk("R3 full count", tx_count, 32);
        chk("R3 full flag", tx_full, 1);
        chk("R4 tx afull", tx_afull, 1);
        chk("R7 no ovf before", irq_status[B_TX_OVF], 0);
        tx_push(16'hDEAD);
        chk("R7 count held", tx_count, 32);
        chk("R7 ovf status", irq_status[B_TX_OVF], 1);
        chk("R2 first after fill", ser_tx_word, {1'b1, 16'h0200});
        for (int i = 0; i < 31; i++) tx_pop();
        chk("R7 last kept sample", ser_tx_word, {1'b1, 16'h021F});
        tx_pop();
        chk("R7 drained", tx_count, 0);

        // starvation on receive
        clear_all();
        chk("R10 starve cleared", irq_status[B_RX_STARVE], 0);
        bus_rx_rd = 1'b1; tick(); bus_rx_rd = 1'b0;
        chk("R8 starve count", rx_count, 0);
        chk("R8 starve word", bus_rx_word, 0);
        chk("R8 starve status", irq_status[B_RX_STARVE], 1);

        // receive thresholds, clear priority, level latency
        rx_dma_en = 1'b1;
        rx_push(16'hB000); rx_push(16'hB001);
        chk("R5 rx aempty at margin", rx_aempty, 1);
        chk("R5 rx afull below thr", rx_afull, 0);
        chk("R6 rx dma below thr", rx_dma_req, 0);
        clear_all();
        chk("R10 starve bit cleared", irq_status[B_RX_STARVE], 0);
        chk("R10 afull cleared", irq_status[B_RX_AFULL], 0);
        chk("R10 set wins over clear", irq_status[B_RX_AEMPTY], 1);
        rx_push(16'hB002);
        chk("R5 rx afull at thr", rx_afull, 1);
        chk("R6 rx dma at thr", rx_dma_req, 1);
        chk("R9 status not yet", irq_status[B_RX_AFULL], 0);
        tick();
        chk("R9 status one edge later", irq_status[B_RX_AFULL], 1);

        // interrupt combine
        irq_en_mask = 12'h004;
        #1;
        chk("R11 pending", irq_status[B_PEND], 1);
        chk("R11 master off", irq, 0);
        irq_master_en = 1'b1;
        #1;
        chk("R11 master on", irq, 1);
        irq_en_mask = 12'h080;
        #1;
        chk("R11 masked pending", irq_status[B_PEND], 0);
        chk("R11 masked irq", irq, 0);

        // disable flush
        tx_push(16'h0301); tx_push(16'h0302); tx_push(16'h0303);
        tx_fifo_en = 1'b0;
        tick();
        chk("R12 flushed count", tx_count, 0);
        chk("R12 flushed empty", tx_empty, 1);
        clear_all();
        bus_tx_wr = 1'b1; ser_tx_rd = 1'b1; bus_tx_data = 16'h0999;
        tick();
        bus_tx_wr = 1'b0; ser_tx_rd = 1'b0;
        tick();
        chk("R12 disabled write ignored", tx_count, 0);
        chk("R12 no ovf while off", irq_status[B_TX_OVF], 0);
        chk("R12 no starve while off", irq_status[B_TX_STARVE], 0);
        chk("R12 no empty latch while off", irq_status[B_TX_EMPTY], 0);
        tx_fifo_en = 1'b1;
        tick();
        chk("R12 re-enable count", tx_count, 0);
        chk("R12 no stale word", ser_tx_word, 0);

        finish_run();
    end
endmodule